// File: doc/BRIEF.md
# One-Time-Programmable Region Controller

This block owns a small one-time-programmable (OTP) region that sits beside a flash main array and shares its command bus. Out of OTP mode it only watches the bus for the entry sequence. Once that sequence is seen, the block takes over every read and write on the bus until the exit sequence returns the device to array read. While it is active, a normal two-cycle program sequence targets the OTP words and not the array.

The region holds three parts. Four factory words contain a fixed 64-bit code that can never be written. Four user words start blank, and a program can only clear their bits. One lock bit permanently shuts the user words once it has been programmed to zero. A program occupies the block for a fixed number of cycles, which stands in for the high-voltage pulse. From the moment the first program is accepted, reads return the status byte until the mode is left. To see the stored words again, software must exit and then re-enter.

Top module: `otp_ctrl`

## Requirements
- R1: While reset is held, and immediately after it, `otp_mode` and `otp_busy` are 0 and `otp_rdata` is 0x0000. Reset models a blank part: user words are 0xFFFF and the lock bit is 1.
- R2: Two consecutive bus writes whose low byte is 0xAF set `otp_mode`. Any other write between the two cancels the entry.
- R3: In OTP mode, two consecutive accepted writes with low byte 0xFF clear `otp_mode`. A single 0xFF followed by any other write leaves the mode set.
- R4: In OTP mode, before any program since entry, a read returns the following by address:
  - addresses 0x00 to 0x03 return slice [16*a+15:16*a] of `FACTORY_CODE`;
  - addresses 0x20 to 0x23 return user words 0 to 3;
  - address 0x40 returns {lock bit, 15 ones};
  - every other address returns 0xFFFF.
- R5: In OTP mode, a write with low byte 0x10 or 0x40 followed by a data write at an address starts a program. `otp_busy` is then high for exactly `PROG_CYCLES` cycles, and every write that arrives while it is high is ignored.
- R6: From the first program attempt after entry until exit, reads return the status word {8'h00, ready, 5'b0, locked, 1'b0}. The ready bit (bit 7) is the inverse of `otp_busy`. The locked bit (bit 1) is set by a refused program.
- R7: A completed program stores (old AND data), so a program can only turn bits from 1 to 0.
- R8: A program to a factory word or to an unmapped address is refused. No busy period follows, status bit 1 is set, and no stored word changes.
- R9: A completed program at address 0x40 with bit 15 = 0 clears the lock bit. After that, programs to user words are refused as in R8. Address 0x40 itself stays programmable.
- R10: Entering OTP mode clears status bit 1.
- R11: Outside OTP mode, `otp_rdata` is 0x0000 and no write other than the entry pair has any effect. In particular a program sequence raises no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe on the shared command bus |
| bus_addr | input | ADDR_W | Word address for reads and program data |
| bus_wdata | input | 16 | Write data; commands use the low byte |
| otp_mode | output | 1 | OTP mode is active and overrides array accesses |
| otp_busy | output | 1 | An OTP program is in progress |
| otp_rdata | output | 16 | Read data for the current address (0 outside OTP mode) |

## Verification
Two functions can fall on the same clock edge: completion of a program and the arrival of a new command write. To provoke this, the bench counts busy cycles and drives an exit-code write so that it is sampled on the very edge at which the program finishes. The write must be lost, because busy is still high at that edge. This is judged by sending a single further exit code followed by another write, and checking that OTP mode remains set. The bench also checks that the status word shows ready one cycle after the program completes.

// File: rtl/otp_pkg.sv
// Package: command codes, region map and status bit positions for the OTP controller.
package otp_pkg;
    localparam logic [7:0] CMD_ENTER   = 8'hAF;
    localparam logic [7:0] CMD_EXIT    = 8'hFF;
    localparam logic [7:0] CMD_PROG_A  = 8'h10;
    localparam logic [7:0] CMD_PROG_B  = 8'h40;
    localparam int         USER_BASE   = 32'h20;
    localparam int         LOCK_ADDR   = 32'h40;
    localparam int         USER_WORDS  = 4;
    localparam int         FACT_WORDS  = 4;
    localparam int         SR_READY    = 7;
    localparam int         SR_LOCKED   = 1;
endpackage

// File: rtl/otp_cmd_fsm.sv
// Command decoder for OTP mode.
// It tracks the doubled entry and exit codes, the program-setup state and the
// read view (contents or status). It assumes one bus write per strobe cycle and
// that the caller reports busy from the program timer.
module otp_cmd_fsm #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              busy,
    output logic              mode,
    output logic              status_view,
    output logic              prog_req,
    output logic              enter_evt,
    output logic [ADDR_W-1:0] req_addr,
    output logic [15:0]       req_data
);
    import otp_pkg::*;

    logic       mode_q, enter_half_q, exit_half_q, setup_q, view_q;
    logic [7:0] code;
    logic       accept;

    // Decode helpers for the current bus write.
    always_comb begin
        code      = bus_wdata[7:0];
        accept    = bus_we && mode_q && !busy;
        prog_req  = accept && setup_q;
        enter_evt = bus_we && !mode_q && enter_half_q && (code == CMD_ENTER);
        req_addr  = bus_addr;
        req_data  = bus_wdata;
    end

    // Mode, half-sequence and view state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= 1'b0;
            enter_half_q <= 1'b0;
            exit_half_q  <= 1'b0;
            setup_q      <= 1'b0;
            view_q       <= 1'b0;
        end else if (bus_we && !mode_q) begin
            if (enter_evt) begin
                mode_q       <= 1'b1;
                enter_half_q <= 1'b0;
                view_q       <= 1'b0;
                setup_q      <= 1'b0;
                exit_half_q  <= 1'b0;
            end else begin
                enter_half_q <= (code == CMD_ENTER);
            end
        end else if (accept) begin
            if (setup_q) begin
                setup_q     <= 1'b0;
                view_q      <= 1'b1;
                exit_half_q <= 1'b0;
            end else if (exit_half_q && code == CMD_EXIT) begin
                mode_q      <= 1'b0;
                exit_half_q <= 1'b0;
            end else begin
                exit_half_q <= (code == CMD_EXIT);
                setup_q     <= (code == CMD_PROG_A) || (code == CMD_PROG_B);
            end
        end
    end

    assign mode        = mode_q;
    assign status_view = view_q;
endmodule

// File: rtl/otp_prog_timer.sv
// Program timer: holds busy for PROG_CYCLES cycles after a start pulse and
// flags the completing edge. It assumes no start arrives while busy.
module otp_prog_timer #(
    parameter int PROG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (start)            cnt_q <= CW'(PROG_CYCLES);
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/otp_store.sv
// OTP storage: the factory code (constant), the user words, the lock bit and the
// sticky refusal flag. It decides whether a program target may be written and
// applies AND-only updates at commit. Reset models a blank part.
module otp_store #(
    parameter int          ADDR_W       = 7,
    parameter logic [63:0] FACTORY_CODE = 64'h1357_9BDF_2468_ACE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    input  logic              start,
    input  logic              refuse,
    input  logic              commit,
    input  logic              clr_err,
    output logic              allowed,
    output logic [15:0]       rd_word,
    output logic              lock_err,
    output logic              lock_bit,
    output logic [16*otp_pkg::USER_WORDS-1:0] user_flat
);
    import otp_pkg::*;

    localparam logic [ADDR_W-1:0] USER_A = ADDR_W'(USER_BASE);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

    logic [15:0]       user_q [USER_WORDS];
    logic              lock_q, err_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [15:0]       tgt_data_q;
    logic              rd_user, rd_fact, req_user;

    // Program target permission check.
    always_comb begin
        req_user = (req_addr[ADDR_W-1:2] == USER_A[ADDR_W-1:2]);
        allowed  = (req_user && lock_q) || (req_addr == LOCK_A);
    end

    // Read mux over factory, user and lock words.
    always_comb begin
        rd_fact = (rd_addr[ADDR_W-1:2] == '0);
        rd_user = (rd_addr[ADDR_W-1:2] == USER_A[ADDR_W-1:2]);
        if (rd_fact)                rd_word = FACTORY_CODE[{rd_addr[1:0], 4'b0000} +: 16];
        else if (rd_user)           rd_word = user_q[rd_addr[1:0]];
        else if (rd_addr == LOCK_A) rd_word = {lock_q, 15'h7FFF};
        else                        rd_word = 16'hFFFF;
    end

    // Latch the accepted program target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr_q <= '0;
            tgt_data_q <= 16'hFFFF;
        end else if (start) begin
            tgt_addr_q <= req_addr;
            tgt_data_q <= req_data;
        end
    end

    // User words: AND the latched data in at commit.
    for (genvar w = 0; w < USER_WORDS; w++) begin : g_user
        always_ff @(posedge clk) begin
            if (!rst_n)
                user_q[w] <= 16'hFFFF;
            else if (commit && tgt_addr_q == USER_A + ADDR_W'(w))
                user_q[w] <= user_q[w] & tgt_data_q;
        end
        assign user_flat[16*w +: 16] = user_q[w];
    end

    // Lock bit and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            if (commit && tgt_addr_q == LOCK_A) lock_q <= lock_q & tgt_data_q[15];
            if (clr_err)                        err_q  <= 1'b0;
            else if (refuse)                    err_q  <= 1'b1;
        end
    end

    assign lock_err = err_q;
    assign lock_bit = lock_q;
endmodule

// File: rtl/otp_ctrl.sv
// Top of the OTP region controller. It joins the command decoder, the program
// timer and the storage, and forms the read data (contents, status or zero).
// It assumes the main command decoder yields the bus while otp_mode is high.
module otp_ctrl #(
    parameter int          ADDR_W       = 7,
    parameter int          PROG_CYCLES  = 8,
    parameter logic [63:0] FACTORY_CODE = 64'h1357_9BDF_2468_ACE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic              otp_mode,
    output logic              otp_busy,
    output logic [15:0]       otp_rdata
);
    import otp_pkg::*;

    logic              status_view, prog_req, enter_evt, allowed, done;
    logic              lock_err, lock_bit;
    logic [ADDR_W-1:0] req_addr;
    logic [15:0]       req_data, rd_word;
    logic [15:0]       status_word;
    logic [16*USER_WORDS-1:0] user_flat;

    otp_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(otp_busy), .mode(otp_mode),
        .status_view(status_view), .prog_req(prog_req), .enter_evt(enter_evt),
        .req_addr(req_addr), .req_data(req_data)
    );

    otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(prog_req && allowed),
        .busy(otp_busy), .done(done)
    );

    otp_store #(.ADDR_W(ADDR_W), .FACTORY_CODE(FACTORY_CODE)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .req_addr(req_addr),
        .req_data(req_data), .start(prog_req && allowed),
        .refuse(prog_req && !allowed), .commit(done), .clr_err(enter_evt),
        .allowed(allowed), .rd_word(rd_word), .lock_err(lock_err),
        .lock_bit(lock_bit), .user_flat(user_flat)
    );

    // Read data: zero outside the mode, status or contents inside it.
    always_comb begin
        status_word            = 16'h0000;
        status_word[SR_READY]  = !otp_busy;
        status_word[SR_LOCKED] = lock_err;
        if (!otp_mode)         otp_rdata = 16'h0000;
        else if (status_view)  otp_rdata = status_word;
        else                   otp_rdata = rd_word;
    end
endmodule

// File: rtl/otp_ctrl_chk.sv
// Checker for otp_ctrl, attached by bind. It watches the ports plus the stored
// user words and lock bit, which the storage drives.
module otp_ctrl_chk #(
    parameter int PROG_CYCLES = 8,
    parameter int UW          = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          otp_mode,
    input logic          otp_busy,
    input logic [15:0]   otp_rdata,
    input logic [UW-1:0] user_flat,
    input logic          lock_bit
);
    localparam int CW = $clog2(PROG_CYCLES + 2);

    logic [UW-1:0] prev_user;
    logic          prev_lock, pv;
    logic [CW-1:0] run;

    // History for monotonic-storage checks and busy run length.
    always_ff @(posedge clk) begin
        prev_user <= user_flat;
        prev_lock <= lock_bit;
        if (!rst_n) begin
            pv  <= 1'b0;
            run <= '0;
        end else begin
            pv  <= 1'b1;
            run <= otp_busy ? run + 1'b1 : '0;
        end
    end

    AST_BUSY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        otp_busy |-> otp_mode); // R5
    AST_BUSY_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run <= CW'(PROG_CYCLES)); // R5
    AST_ENTRY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otp_mode) |-> $past(bus_we)); // R2
    AST_EXIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(otp_mode) |-> ($past(bus_we) && !$past(otp_busy))); // R3
    AST_STATUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        otp_busy |-> (otp_rdata[15:8] == 8'h00 && !otp_rdata[7])); // R6
    AST_USER_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> ((~prev_user & user_flat) == '0)); // R7
    AST_LOCK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> !(lock_bit && !prev_lock)); // R9
    AST_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !otp_mode |-> (otp_rdata == 16'h0000)); // R11
endmodule

bind otp_ctrl otp_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES), .UW(16*otp_pkg::USER_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .otp_mode(otp_mode),
    .otp_busy(otp_busy), .otp_rdata(otp_rdata), .user_flat(user_flat),
    .lock_bit(lock_bit)
);

// File: tb/sim_otp_ctrl.sv
module sim_otp_ctrl;
    localparam int          AW = 7;
    localparam int          PC = 8;
    localparam logic [63:0] FC = 64'h1357_9BDF_2468_ACE0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          otp_mode, otp_busy;
    logic [15:0]   otp_rdata;

    int n_chk = 0, n_bad = 0;
    logic [15:0] user_exp [4];
    logic        lock_exp;

    always #2 clk = ~clk;

    otp_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC), .FACTORY_CODE(FC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .otp_mode(otp_mode), .otp_busy(otp_busy),
        .otp_rdata(otp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int a);
        if (a < 4)                    return FC[16*a +: 16];
        else if (a >= 'h20 && a < 'h24) return user_exp[a - 'h20];
        else if (a == 'h40)           return {lock_exp, 15'h7FFF};
        else                          return 16'hFFFF;
    endfunction

    task automatic rd_chk(input string req, input int a);
        bus_addr = AW'(a);
        #1;
        chk(req, otp_rdata, exp_word(a));
    endtask

    task automatic reenter();
        wr('0, 16'h00FF); wr('0, 16'h00FF);
        wr('0, 16'h00AF); wr('0, 16'h00AF);
    endtask

    // Program an allowed target; checks busy length and status (R5, R6, R7).
    task automatic prog_ok(input int a, input logic [15:0] d);
        int busy_n;
        wr('0, 16'h0040);
        wr(AW'(a), d);
        busy_n = 0;
        while (otp_busy && busy_n < 4 * PC) begin
            if (busy_n == 0) chk("R6 status while busy", otp_rdata & 16'hFF7D, 16'h0000);
            busy_n++;
            @(negedge clk);
        end
        chk("R5 busy length", busy_n, PC);
        chk("R6 status ready", otp_rdata & 16'hFFFD, 16'h0080);
        if (a >= 'h20 && a < 'h24) user_exp[a - 'h20] &= d;
        if (a == 'h40) lock_exp &= d[15];
    endtask

    task automatic prog_refused(input string req, input int a, input logic [15:0] d);
        wr('0, 16'h0010);
        wr(AW'(a), d);
        chk({req, " no busy"}, otp_busy, 1'b0);
        chk({req, " locked status"}, otp_rdata, 16'h0082);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) user_exp[i] = 16'hFFFF;
        lock_exp = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", otp_mode, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", otp_mode, 1'b0);
        chk("R1 busy", otp_busy, 1'b0);
        chk("R1 rdata", otp_rdata, 16'h0000);

        // R11: stray writes outside the mode do nothing
        wr('0, 16'h0040); wr(7'h20, 16'h0000);
        chk("R11 no busy outside", otp_busy, 1'b0);
        chk("R11 rdata zero", otp_rdata, 16'h0000);
        // R2: broken entry pair
        wr('0, 16'h00AF); wr('0, 16'h0012); wr('0, 16'h00AF);
        chk("R2 broken pair", otp_mode, 1'b0);
        wr('0, 16'h00AF);
        chk("R2 entry", otp_mode, 1'b1);

        // R4: sweep every address
        for (int a = 0; a < 128; a++) rd_chk("R4 read map", a);

        // R3: broken exit pair keeps the mode
        wr('0, 16'h00FF); wr('0, 16'h0000); wr('0, 16'h00FF); wr('0, 16'h0001);
        chk("R3 broken exit", otp_mode, 1'b1);

        // R5 coincidence: exit code sampled on the completing edge is lost
        wr('0, 16'h0010);
        wr(7'h20, 16'hA5F0);
        for (int k = 1; k < PC; k++) @(negedge clk);
        bus_we = 1'b1; bus_wdata = 16'h00FF;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R5 busy ended", otp_busy, 1'b0);
        user_exp[0] &= 16'hA5F0;
        wr('0, 16'h00FF); wr('0, 16'h0003);
        chk("R5 write on completing edge ignored", otp_mode, 1'b1);
        chk("R6 status after", otp_rdata, 16'h0080);

        // R7: patterns over every user word, twice each
        for (int w = 0; w < 4; w++) begin
            prog_ok('h20 + w, 16'hFFFF ^ (16'h0101 << w));
            prog_ok('h20 + w, 16'h5A5A ^ (16'h1111 * w[15:0]));
        end
        reenter();
        for (int w = 0; w < 4; w++) rd_chk("R7 AND-only contents", 'h20 + w);
        rd_chk("R3 re-entry shows contents", 0);

        // R8: refused targets
        prog_refused("R8 factory", 2, 16'h0000);
        prog_refused("R8 unmapped", 'h30, 16'h0000);
        reenter();
        rd_chk("R8 factory unchanged", 2);
        rd_chk("R8 unmapped unchanged", 'h30);
        // R10: error flag cleared by entry
        prog_ok('h23, 16'hFFFE);
        chk("R10 locked bit cleared", otp_rdata, 16'h0080);

        // R9: lock the user half
        prog_ok('h40, 16'h7FFF);
        prog_refused("R9 user after lock", 'h21, 16'h0000);
        reenter();
        rd_chk("R9 lock word", 'h40);
        rd_chk("R9 user word unchanged", 'h21);

        // R11: leave and confirm silence
        wr('0, 16'h00FF); wr('0, 16'h00FF);
        chk("R3 exit", otp_mode, 1'b0);
        wr('0, 16'h0010); wr(7'h22, 16'h0000);
        chk("R11 program ignored outside", otp_busy, 1'b0);
        chk("R11 rdata outside", otp_rdata, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule